// File: doc/BRIEF.md
# Serial Result Framer

This block sends each conversion result out on a three-wire serial link while the successive-approximation conversion is still running. A convert-start event opens a frame, and the frame carries sixteen bit slots: four zero pad slots, then the twelve result bits, most significant first. The conversion controller passes each result bit in as soon as it has decided that bit. The framer stores the bit and paces the serial clock so that a slot is never sent before its bit exists.

All three lines are open-drain. The block drives a pull-low enable for each line (serial clock, active-low frame strobe and serial data). It also gives the resolved line level that an external pull-up would produce, for use by checkers. A mode input picks the clock behaviour. In continuous mode the serial clock toggles on every conversion-clock cycle outside a frame. In gated mode it rests released (high) outside a frame, so several converters can share one bus. A format input turns the serial port off for the parallel-only format.

Top module: `serialFramer`

## Requirements
- R1: While reset is asserted and in the cycle after it, none of the three lines is pulled low, so all resolved levels read 1.
- R2: When convStart is sampled high on an edge while no frame is in progress and serialEn is 1, the strobe is pulled low at the second or third clock edge after that edge.
- R3: While the strobe is low, the frame has exactly 16 falling edges of the serial clock. At those edges the data line level is 0,0,0,0 and then result bits 11 down to 0, where a released line (level 1) is a 1 bit and a pulled line is a 0 bit. The result bit order is the order in which resBitValid delivers them, most significant first.
- R4: Inside a frame, the data line changes only on an edge where the serial clock rises.
- R5: The strobe is released on the clock edge after the 16th falling serial-clock edge. The data line is released whenever the strobe is released.
- R6: In continuous mode (clkFree = 1) with serialEn = 1, the serial clock toggles on every clock edge outside a frame.
- R7: In gated mode (clkFree = 0), the serial clock stays released (high) outside a frame.
- R8: A result slot whose bit has not yet been delivered is held with the serial clock low until the bit arrives, so no falling edge ever samples an undelivered bit.
- R9: With serialEn = 0 (parallel format), all three lines are released on the next edge and convStart is ignored.
- R10: A convStart pulse during a frame is ignored. The frame in progress finishes unchanged and no second strobe fall occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serialEn | input | 1 | 1 selects a serial-capable format, 0 the parallel-only format |
| clkFree | input | 1 | 1 selects a continuously running serial clock, 0 a gated one |
| convStart | input | 1 | Convert-start event, sampled on the clock |
| resBitValid | input | 1 | One-cycle pulse when the controller has decided the next result bit |
| resBitValue | input | 1 | Value of the decided bit, MSB first |
| sclkPullLow | output | 1 | Pull-low enable of the serial clock line |
| strbPullLow | output | 1 | Pull-low enable of the frame strobe line |
| sdataPullLow | output | 1 | Pull-low enable of the serial data line |
| sclkLine | output | 1 | Resolved serial clock level |
| strbLine | output | 1 | Resolved strobe level |
| sdataLine | output | 1 | Resolved data level |

## Verification
The bench drives results with random gaps between delivered bits and includes a long stall in the middle of the result. A framer that ignored bit readiness would sample the stale bit from the previous frame and put wrong result bits into the captured word. It also checks the start latency in both clock modes, where the continuous clock adds a phase-alignment cycle; a design that skipped the alignment would open the frame without a rising edge and shift the captured word. A start pulse inside a frame and a start pulse with the port turned off must both leave the lines unchanged. The idle clock must toggle on every cycle in one mode and stay high in the other.

// File: rtl/serialFramerPkg.sv
package serialFramerPkg;

  typedef enum logic [1:0] {
    stIdle,
    stArm,
    stHigh,
    stLow
  } frameStateT;

  typedef struct packed {
    logic clearRes;
    logic acceptBits;
    logic loadSlot;
    logic releaseAll;
  } framerCmdT;

endpackage

// File: rtl/serialFramerCtrl.sv
module serialFramerCtrl
  import serialFramerPkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int IDX_W   = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serialEn,
  input  logic             clkFree,
  input  logic             convStart,
  input  logic             slotReady,
  output framerCmdT        cmd,
  output logic [IDX_W-1:0] loadIdx,
  output logic             sclkPullLow
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);

  frameStateT       state, nxtState;
  logic [IDX_W-1:0] slotIdx, nxtIdx, nextSlot;
  logic             sclkQ, nxtSclk;

  assign nextSlot    = slotIdx + IDX_ONE;
  assign loadIdx     = (state == stArm) ? '0 : nextSlot;
  assign sclkPullLow = sclkQ;

  always_comb begin
    nxtState = state;
    nxtIdx   = slotIdx;
    nxtSclk  = sclkQ;
    cmd      = '0;
    if (!serialEn) begin
      nxtState       = stIdle;
      nxtSclk        = 1'b0;
      cmd.releaseAll = 1'b1;
    end else begin
      case (state)
        stIdle: begin
          nxtSclk = clkFree ? ~sclkQ : 1'b0;
          if (convStart) begin
            nxtState     = stArm;
            cmd.clearRes = 1'b1;
          end
        end
        stArm: begin
          cmd.acceptBits = 1'b1;
          if (!clkFree || sclkQ) begin
            nxtState     = stHigh;
            nxtSclk      = 1'b0;
            nxtIdx       = '0;
            cmd.loadSlot = 1'b1;
          end else begin
            nxtSclk = 1'b1;
          end
        end
        stHigh: begin
          cmd.acceptBits = 1'b1;
          nxtState       = stLow;
          nxtSclk        = 1'b1;
        end
        stLow: begin
          cmd.acceptBits = 1'b1;
          if (slotIdx == LAST_SLOT) begin
            nxtState       = stIdle;
            nxtSclk        = 1'b0;
            cmd.releaseAll = 1'b1;
          end else if (slotReady) begin
            nxtState     = stHigh;
            nxtSclk      = 1'b0;
            nxtIdx       = nextSlot;
            cmd.loadSlot = 1'b1;
          end
        end
        default: nxtState = stIdle;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= stIdle;
      slotIdx <= '0;
      sclkQ   <= 1'b0;
    end else begin
      state   <= nxtState;
      slotIdx <= nxtIdx;
      sclkQ   <= nxtSclk;
    end
  end

endmodule

// File: rtl/serialFramerData.sv
module serialFramerData
  import serialFramerPkg::*;
#(
  parameter int RES_W   = 12,
  parameter int PAD_W   = 4,
  parameter int FRAME_W = RES_W + PAD_W,
  parameter int IDX_W   = $clog2(FRAME_W),
  parameter int CNT_W   = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  framerCmdT        cmd,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic             bitValid,
  input  logic             bitValue,
  output logic             slotReady,
  output logic             strbPullLow,
  output logic             sdataPullLow
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [RES_W-1:0] resBits;
  logic [CNT_W-1:0] resCnt;
  logic             strbQ, dataQ;
  logic             slotBit;

  // Pad slots match no stored bit and stay zero.
  always_comb begin
    slotBit = 1'b0;
    for (int b = 0; b < RES_W; b++) begin
      if (int'(loadIdx) == FRAME_W - 1 - b) slotBit = resBits[b];
    end
  end

  // A slot is ready once its result bit (if any) has been delivered.
  assign slotReady    = (int'(resCnt) + PAD_W) > int'(loadIdx);
  assign strbPullLow  = strbQ;
  assign sdataPullLow = dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resBits <= '0;
      resCnt  <= '0;
      strbQ   <= 1'b0;
      dataQ   <= 1'b0;
    end else begin
      if (cmd.clearRes) begin
        resCnt <= bitValid ? CNT_ONE : '0;
        if (bitValid) resBits[RES_W-1] <= bitValue;
      end else if (cmd.acceptBits && bitValid && int'(resCnt) < RES_W) begin
        for (int b = 0; b < RES_W; b++) begin
          if (b == RES_W - 1 - int'(resCnt)) resBits[b] <= bitValue;
        end
        resCnt <= resCnt + CNT_ONE;
      end
      if (cmd.releaseAll) begin
        strbQ <= 1'b0;
        dataQ <= 1'b0;
      end else if (cmd.loadSlot) begin
        strbQ <= 1'b1;
        dataQ <= ~slotBit;
      end
    end
  end

endmodule

// File: rtl/serialFramer.sv
module serialFramer
  import serialFramerPkg::*;
#(
  parameter int RES_W = 12,
  parameter int PAD_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic serialEn,
  input  logic clkFree,
  input  logic convStart,
  input  logic resBitValid,
  input  logic resBitValue,
  output logic sclkPullLow,
  output logic strbPullLow,
  output logic sdataPullLow,
  output logic sclkLine,
  output logic strbLine,
  output logic sdataLine
);

  localparam int FRAME_W = RES_W + PAD_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int CNT_W   = $clog2(RES_W + 1);

  framerCmdT        cmd;
  logic [IDX_W-1:0] loadIdx;
  logic             slotReady;

  serialFramerCtrl #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .serialEn   (serialEn),
    .clkFree    (clkFree),
    .convStart  (convStart),
    .slotReady  (slotReady),
    .cmd        (cmd),
    .loadIdx    (loadIdx),
    .sclkPullLow(sclkPullLow)
  );

  serialFramerData #(
    .RES_W(RES_W), .PAD_W(PAD_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .loadIdx     (loadIdx),
    .bitValid    (resBitValid),
    .bitValue    (resBitValue),
    .slotReady   (slotReady),
    .strbPullLow (strbPullLow),
    .sdataPullLow(sdataPullLow)
  );

  assign sclkLine  = ~sclkPullLow;
  assign strbLine  = ~strbPullLow;
  assign sdataLine = ~sdataPullLow;

endmodule

// File: rtl/serialFramerChk.sv
module serialFramerChk (
  input logic clk,
  input logic rstN,
  input logic serialEn,
  input logic clkFree,
  input logic convStart,
  input logic sclkPullLow,
  input logic strbPullLow,
  input logic sdataPullLow
);

  assert_reset_release_R1: assert property (@(posedge clk)
    !rstN |=> (!sclkPullLow && !strbPullLow && !sdataPullLow));

  assert_strobe_after_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strbPullLow) |-> ($past(convStart, 2) || $past(convStart, 3)));

  assert_data_on_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strbPullLow) && strbPullLow && (sdataPullLow != $past(sdataPullLow)))
      |-> $fell(sclkPullLow));

  assert_data_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strbPullLow |-> !sdataPullLow);

  assert_strobe_end_low_clk_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $fell(strbPullLow) && $past(serialEn)) |-> $past(sclkPullLow));

  assert_free_clock_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(clkFree) && $past(serialEn) && !$past(strbPullLow) && !strbPullLow)
      |-> (sclkPullLow != $past(sclkPullLow)));

  assert_gated_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(clkFree) && !strbPullLow) |-> !sclkPullLow);

  assert_port_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !serialEn |=> (!sclkPullLow && !strbPullLow && !sdataPullLow));

endmodule

bind serialFramer serialFramerChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .serialEn    (serialEn),
  .clkFree     (clkFree),
  .convStart   (convStart),
  .sclkPullLow (sclkPullLow),
  .strbPullLow (strbPullLow),
  .sdataPullLow(sdataPullLow)
);

// File: tb/test_serialFramer.sv
module test_serialFramer;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, serialEn, clkFree, convStart, resBitValid, resBitValue;
  logic sclkPullLow, strbPullLow, sdataPullLow, sclkLine, strbLine, sdataLine;

  serialFramer i_serialFramer (
    .clk(clk), .rstN(rstN), .serialEn(serialEn), .clkFree(clkFree),
    .convStart(convStart), .resBitValid(resBitValid), .resBitValue(resBitValue),
    .sclkPullLow(sclkPullLow), .strbPullLow(strbPullLow), .sdataPullLow(sdataPullLow),
    .sclkLine(sclkLine), .strbLine(strbLine), .sdataLine(sdataLine)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic prevSclk = 1'b1, prevStrb = 1'b1, prevData = 1'b1;
  logic cap [32];
  int capCnt, strbFalls, strbFallCyc, strbRiseCyc, lastCapCyc, capAtRise;
  int issued, r4Viol, r8Viol, startCyc;
  bit done = 1'b0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: wait for the falling edge, then observe the resolved lines.
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (prevSclk && !sclkLine && !strbLine) begin
      if (capCnt < 32) cap[capCnt] = sdataLine;
      if (capCnt >= 4 && issued < capCnt - 3) r8Viol++;
      capCnt++;
      lastCapCyc = cyc;
    end
    if (prevStrb && !strbLine) begin
      strbFalls++;
      strbFallCyc = cyc;
    end
    if (!prevStrb && strbLine) begin
      strbRiseCyc = cyc;
      capAtRise   = capCnt;
    end
    if (!prevStrb && !strbLine && (sdataLine != prevData) && !(!prevSclk && sclkLine)) r4Viol++;
    prevSclk = sclkLine;
    prevStrb = strbLine;
    prevData = sdataLine;
  endtask

  function automatic logic [15:0] expectFrame(logic [11:0] res);
    return {4'b0000, res};
  endfunction

  task automatic clearMon();
    capCnt = 0; strbFalls = 0; strbFallCyc = -1; strbRiseCyc = -1;
    lastCapCyc = -1; capAtRise = -1; issued = 0; r4Viol = 0; r8Viol = 0;
  endtask

  task automatic runFrame(logic [11:0] res, int maxGap, int stallAt, int stallLen, bit poke);
    logic [15:0] got;
    int d;
    int guard;
    clearMon();
    convStart = 1'b1;
    startCyc  = cyc;
    tick();
    convStart = 1'b0;
    for (int i = 0; i < 12; i++) begin
      int gap;
      gap = (i == stallAt) ? stallLen : int'($urandom_range(maxGap, 0));
      repeat (gap) tick();
      if (poke && i == 6) begin
        convStart = 1'b1;
        tick();
        convStart = 1'b0;
      end
      resBitValid = 1'b1;
      resBitValue = res[11-i];
      issued++;
      tick();
      resBitValid = 1'b0;
    end
    guard = 0;
    while (strbRiseCyc < 0 && guard < 400) begin
      tick();
      guard++;
    end
    got = '0;
    for (int k = 0; k < 16; k++) got[15-k] = (k < capCnt) ? cap[k] : 1'b0;
    check("R3 frame word", int'(got), int'(expectFrame(res)));
    check("R5 falling edges before strobe release", capAtRise, 16);
    d = strbFallCyc - startCyc;
    check("R2 strobe latency in 2..3", int'(d >= 2 && d <= 3), 1);
    check("R5 strobe release after last falling edge", strbRiseCyc, lastCapCyc + 1);
    check("R4 data changed off rising clock", r4Viol, 0);
    check("R8 undelivered bit sampled", r8Viol, 0);
    if (poke) check("R10 strobe falls in poked frame", strbFalls, 1);
    tick();
    check("R5 data released after frame", int'(sdataLine), 1);
  endtask

  task automatic idleClock(bit expectToggle);
    int toggles = 0, lows = 0;
    logic last;
    tick();
    last = sclkLine;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (sclkLine != last) toggles++;
      if (!sclkLine) lows++;
      last = sclkLine;
    end
    if (expectToggle) check("R6 continuous idle toggles", toggles, 10);
    else check("R7 gated idle clock low samples", lows, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; serialEn = 1'b1; clkFree = 1'b0;
    convStart = 1'b0; resBitValid = 1'b0; resBitValue = 1'b0;
    clearMon();
    repeat (3) tick();
    check("R1 reset sclk line", int'(sclkLine), 1);
    check("R1 reset strobe line", int'(strbLine), 1);
    check("R1 reset data line", int'(sdataLine), 1);
    rstN = 1'b1;
    tick();
    check("R1 strobe released after reset", int'(strbLine), 1);

    // Gated mode
    idleClock(1'b0);
    runFrame(12'hFFF, 0, -1, 0, 1'b0);
    runFrame(12'h800, 1, -1, 0, 1'b0);
    runFrame(12'h001, 2, 5, 25, 1'b0);
    runFrame(12'h000, 0, 0, 12, 1'b0);
    for (int n = 0; n < 6; n++) runFrame(12'($urandom_range(4095, 0)), 3, -1, 0, 1'b0);
    idleClock(1'b0);

    // Continuous mode
    clkFree = 1'b1;
    repeat (2) tick();
    idleClock(1'b1);
    runFrame(12'hA5A, 0, -1, 0, 1'b0);
    runFrame(12'h5A5, 2, -1, 0, 1'b1);
    runFrame(12'h7FF, 1, 9, 30, 1'b0);
    for (int n = 0; n < 5; n++) runFrame(12'($urandom_range(4095, 0)), 3, -1, 0, 1'b0);
    idleClock(1'b1);

    // Parallel-only format
    serialEn = 1'b0;
    tick();
    clearMon();
    begin
      int lowSeen = 0;
      convStart = 1'b1;
      tick();
      convStart = 1'b0;
      for (int i = 0; i < 40; i++) begin
        resBitValid = (i % 3 == 0);
        resBitValue = 1'b0;
        tick();
        if (!sclkLine || !strbLine || !sdataLine) lowSeen++;
      end
      resBitValid = 1'b0;
      check("R9 lines pulled while port off", lowSeen, 0);
      check("R9 strobe falls while port off", strbFalls, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule